// File: doc/BRIEF.md
# Bus Slave to Synchronous Memory Bridge

This block sits between a Wishbone slave port and a simple synchronous data memory that has separate read and write ports, each with its own enable, byte address and size code, plus a write data bus and a read data return. A bus request (cyc and stb both high) is turned into exactly one memory enable in the same cycle: the read enable for a read, the write enable for a write. The byte select is turned into a byte offset and a lane mask. The selected lanes of the bus write data are moved down to bit 0 for the memory, and the data the memory returns is moved back up onto the selected lanes for the bus.

The control is a two-state machine. In `ST_IDLE` the bridge waits; the transition *accept* (cyc and stb high in `ST_IDLE`) fires the memory enable and captures the direction and select. In `ST_RESP` the bridge acknowledges the transfer while the memory's registered read data is valid; the transition *retire* always returns to `ST_IDLE` on the next edge. A transfer therefore takes two cycles, and a master that keeps stb high after the acknowledge starts its next transfer in the cycle after the acknowledge. The memory size code is not taken from the select: it is a constant fixed by the configured port granularity.

Top module: `bus_mem_bridge`

## Requirements
- R1: While reset (rst_ni low) is applied with an idle bus, ack_o, mem_rd_en_o and mem_wr_en_o are all 0.
- R2: When cyc_i and stb_i are not both 1, mem_rd_en_o and mem_wr_en_o are both 0.
- R3: A request with we_i = 0 accepted in `ST_IDLE` drives mem_rd_en_o = 1 and mem_wr_en_o = 0 in that cycle; mem_rd_addr_o is {adr_i, ofs}, where ofs (the low two address bits for a 32-bit bus) is the index of the lowest set bit of sel_i, or 0 when sel_i is 0.
- R4: A request with we_i = 1 accepted in `ST_IDLE` drives mem_wr_en_o = 1 and mem_rd_en_o = 0; mem_wr_addr_o is {adr_i, ofs} as in R3, and mem_wr_data_o is dat_i with every byte lane whose sel_i bit is 0 cleared, then shifted right by 8*ofs bits.
- R5: mem_rd_size_o and mem_wr_size_o always equal the code of the port granularity GRAN_W: 8 bits gives 00, 16 gives 01, 32 gives 10, 64 gives 11 (10 by default).
- R6: ack_o is 1 in exactly the cycle after an accepted request, for one cycle per transfer, and both memory enables are 0 in that acknowledge cycle.
- R7: In the acknowledge cycle of a read, dat_o is the memory read data (registered by the memory at the accepting edge) shifted left by 8*ofs bits with the lanes whose captured sel bit is 0 cleared; on a write acknowledge and whenever ack_o is 0, dat_o is 0.
- R8: mem_rd_en_o and mem_wr_en_o are never 1 together.
- R9: If cyc_i is 0 in the response cycle, ack_o stays 0 (abandoned transfer), and the bridge still returns to `ST_IDLE` and accepts a new request on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Bus write (1) or read (0) |
| adr_i | input | ADDR_W-log2(DATA_W/8) | Bus word address |
| sel_i | input | DATA_W/8 | Byte lane select |
| dat_i | input | DATA_W | Bus write data |
| ack_o | output | 1 | Transfer acknowledge |
| dat_o | output | DATA_W | Bus read data, lane aligned |
| mem_rd_en_o | output | 1 | Memory read enable |
| mem_rd_addr_o | output | ADDR_W | Memory read byte address |
| mem_rd_size_o | output | 2 | Memory read size code |
| mem_wr_en_o | output | 1 | Memory write enable |
| mem_wr_addr_o | output | ADDR_W | Memory write byte address |
| mem_wr_size_o | output | 2 | Memory write size code |
| mem_wr_data_o | output | DATA_W | Memory write data, right aligned |
| mem_rd_data_i | input | DATA_W | Memory read data, right aligned, one cycle after read enable |

## Verification
A state register stuck in `ST_RESP` or `ST_IDLE` shows within one cycle of the next request: either a missing acknowledge, an acknowledge lasting two cycles, or a memory enable firing during the acknowledge cycle. A wrong captured select or direction is seen only in the acknowledge cycle of a read, as read data on the wrong lanes or a non-zero dat_o on a write acknowledge, so the random mix alternates reads and writes with sparse, split and empty selects. Offset and alignment errors on the request side are visible in the very cycle the request is presented.

// File: rtl/bmb_pkg.sv
package bmb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bmb_state_e;

    // Size code of the memory port for a given granularity in bits.
    function automatic logic [1:0] gran_size_code(input int unsigned gran_bits);
        case (gran_bits)
            8:       return 2'b00;
            16:      return 2'b01;
            32:      return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/bmb_sel_decode.sv
module bmb_sel_decode #(
    parameter int SEL_W = 4,
    localparam int OFS_W = $clog2(SEL_W)
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [OFS_W-1:0] ofs_o
);

    // Index of the lowest selected lane; zero when nothing is selected.
    always_comb begin
        ofs_o = '0;
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (sel_i[i]) begin
                ofs_o = OFS_W'(i);
            end
        end
    end

endmodule

// File: rtl/bmb_lane_shift.sv
module bmb_lane_shift #(
    parameter int DATA_W = 32,
    parameter bit TO_MEM = 1'b1,
    localparam int SEL_W = DATA_W / 8,
    localparam int OFS_W = $clog2(SEL_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] lane_mask;
    logic [OFS_W+2:0]  shamt;

    for (genvar g = 0; g < SEL_W; g++) begin : g_lane
        assign lane_mask[8*g +: 8] = {8{sel_i[g]}};
    end

    assign shamt = {ofs_i, 3'b000};

    if (TO_MEM) begin : g_down
        // Bus lanes to memory: keep selected lanes, move them to bit 0.
        assign data_o = (data_i & lane_mask) >> shamt;
    end else begin : g_up
        // Memory to bus lanes: move up to the offset, clear unselected lanes.
        assign data_o = (data_i << shamt) & lane_mask;
    end

endmodule

// File: rtl/bmb_fsm.sv
module bmb_fsm
    import bmb_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic             we_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             accept_o,
    output logic             ack_o,
    output logic             resp_rd_o,
    output logic [SEL_W-1:0] resp_sel_o
);

    bmb_state_e state_q, state_d;
    logic             resp_rd_q;
    logic [SEL_W-1:0] resp_sel_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        ack_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept_o = cyc_i && stb_i;
                if (cyc_i && stb_i) begin
                    state_d = ST_RESP;
                end
            end
            ST_RESP: begin
                ack_o   = cyc_i;
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            resp_rd_q  <= 1'b0;
            resp_sel_q <= '0;
        end else if (state_q == ST_IDLE && cyc_i && stb_i) begin
            resp_rd_q  <= !we_i;
            resp_sel_q <= sel_i;
        end
    end

    assign resp_rd_o  = resp_rd_q;
    assign resp_sel_o = resp_sel_q;

endmodule

// File: rtl/bus_mem_bridge.sv
module bus_mem_bridge
    import bmb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int GRAN_W = 32
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  cyc_i,
    input  logic                                  stb_i,
    input  logic                                  we_i,
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]    adr_i,
    input  logic [DATA_W/8-1:0]                   sel_i,
    input  logic [DATA_W-1:0]                     dat_i,
    output logic                                  ack_o,
    output logic [DATA_W-1:0]                     dat_o,
    output logic                                  mem_rd_en_o,
    output logic [ADDR_W-1:0]                     mem_rd_addr_o,
    output logic [1:0]                            mem_rd_size_o,
    output logic                                  mem_wr_en_o,
    output logic [ADDR_W-1:0]                     mem_wr_addr_o,
    output logic [1:0]                            mem_wr_size_o,
    output logic [DATA_W-1:0]                     mem_wr_data_o,
    input  logic [DATA_W-1:0]                     mem_rd_data_i
);

    localparam int SEL_W = DATA_W / 8;
    localparam int OFS_W = $clog2(SEL_W);
    localparam logic [1:0] SIZE_CODE = gran_size_code(GRAN_W);

    logic             accept;
    logic             resp_rd;
    logic [SEL_W-1:0] resp_sel;
    logic [OFS_W-1:0] req_ofs;
    logic [OFS_W-1:0] rsp_ofs;
    logic [DATA_W-1:0] rd_aligned;

    bmb_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cyc_i      (cyc_i),
        .stb_i      (stb_i),
        .we_i       (we_i),
        .sel_i      (sel_i),
        .accept_o   (accept),
        .ack_o      (ack_o),
        .resp_rd_o  (resp_rd),
        .resp_sel_o (resp_sel)
    );

    bmb_sel_decode #(.SEL_W(SEL_W)) u_req_dec (
        .sel_i (sel_i),
        .ofs_o (req_ofs)
    );

    bmb_sel_decode #(.SEL_W(SEL_W)) u_rsp_dec (
        .sel_i (resp_sel),
        .ofs_o (rsp_ofs)
    );

    bmb_lane_shift #(.DATA_W(DATA_W), .TO_MEM(1'b1)) u_wr_shift (
        .data_i (dat_i),
        .sel_i  (sel_i),
        .ofs_i  (req_ofs),
        .data_o (mem_wr_data_o)
    );

    bmb_lane_shift #(.DATA_W(DATA_W), .TO_MEM(1'b0)) u_rd_shift (
        .data_i (mem_rd_data_i),
        .sel_i  (resp_sel),
        .ofs_i  (rsp_ofs),
        .data_o (rd_aligned)
    );

    assign mem_rd_en_o   = accept && !we_i;
    assign mem_wr_en_o   = accept && we_i;
    assign mem_rd_addr_o = {adr_i, req_ofs};
    assign mem_wr_addr_o = {adr_i, req_ofs};
    assign mem_rd_size_o = SIZE_CODE;
    assign mem_wr_size_o = SIZE_CODE;
    assign dat_o         = (ack_o && resp_rd) ? rd_aligned : '0;

endmodule

// File: rtl/bus_mem_bridge_chk.sv
module bus_mem_bridge_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic cyc_i,
    input logic stb_i,
    input logic we_i,
    input logic ack_o,
    input logic mem_rd_en_o,
    input logic mem_wr_en_o
);

    a_r8_excl_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_en_o && mem_wr_en_o));

    a_r2_no_strobe_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cyc_i && stb_i) |-> !(mem_rd_en_o || mem_wr_en_o));

    a_r3_read_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_en_o |-> !we_i);

    a_r4_write_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_wr_en_o |-> we_i);

    a_r6_ack_follows_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> $past(mem_rd_en_o || mem_wr_en_o));

    a_r6_ack_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);

    a_r6_quiet_during_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> !(mem_rd_en_o || mem_wr_en_o));

    a_r9_ack_needs_cyc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> cyc_i);

endmodule

bind bus_mem_bridge bus_mem_bridge_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_i       (cyc_i),
    .stb_i       (stb_i),
    .we_i        (we_i),
    .ack_o       (ack_o),
    .mem_rd_en_o (mem_rd_en_o),
    .mem_wr_en_o (mem_wr_en_o)
);

// File: tb/bus_mem_bridge_test.sv
`timescale 1ns/1ps
module bus_mem_bridge_test;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int SEL_W  = 4;
    localparam int WADR_W = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [WADR_W-1:0] adr = '0;
    logic [SEL_W-1:0]  sel = '0;
    logic [DATA_W-1:0] dat = '0;
    logic              ack;
    logic [DATA_W-1:0] dat_out;
    logic              rd_en, wr_en;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [1:0]        rd_size, wr_size;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] mem_q = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bus_mem_bridge uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cyc_i         (cyc),
        .stb_i         (stb),
        .we_i          (we),
        .adr_i         (adr),
        .sel_i         (sel),
        .dat_i         (dat),
        .ack_o         (ack),
        .dat_o         (dat_out),
        .mem_rd_en_o   (rd_en),
        .mem_rd_addr_o (rd_addr),
        .mem_rd_size_o (rd_size),
        .mem_wr_en_o   (wr_en),
        .mem_wr_addr_o (wr_addr),
        .mem_wr_size_o (wr_size),
        .mem_wr_data_o (wr_data),
        .mem_rd_data_i (mem_q)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mem_model(input logic [31:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8] + 8'h3C, ~a[7:0], a[7:0] + a[23:16]};
    endfunction

    // Synchronous memory: data registered on the edge that sees the read enable.
    always @(posedge clk) begin
        if (rd_en) mem_q <= mem_model(rd_addr);
    end

    function automatic int exp_ofs(input logic [3:0] s);
        int o = 0;
        for (int i = 3; i >= 0; i--) if (s[i]) o = i;
        return o;
    endfunction

    function automatic logic [31:0] exp_mask(input logic [3:0] s);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{s[i]}};
        return m;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit w, input logic [WADR_W-1:0] a, input logic [3:0] s,
                        input logic [31:0] d, input bit hold);
        int o;
        logic [31:0] ea;
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; sel = s; dat = d;
        #1;
        o  = exp_ofs(s);
        ea = {a, 2'(o)};
        check("R6 ack low in request cycle", 64'(ack), 64'd0);
        if (w) begin
            check("R4 write enables", 64'({wr_en, rd_en}), 64'b10);
            check("R4 write address", 64'(wr_addr), 64'(ea));
            check("R4 write data", 64'(wr_data), 64'((d & exp_mask(s)) >> (8 * o)));
            check("R5 write size", 64'(wr_size), 64'b10);
        end else begin
            check("R3 read enables", 64'({rd_en, wr_en}), 64'b10);
            check("R3 read address", 64'(rd_addr), 64'(ea));
            check("R5 read size", 64'(rd_size), 64'b10);
        end
        @(negedge clk);
        #1;
        check("R6 ack in response cycle", 64'(ack), 64'd1);
        check("R6 enables quiet during ack", 64'({rd_en, wr_en}), 64'd0);
        check("R7 response data", 64'(dat_out),
              w ? 64'd0 : 64'((mem_model(ea) << (8 * o)) & exp_mask(s)));
        if (!hold) begin
            cyc = 1'b0; stb = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R1 ack in reset", 64'(ack), 64'd0);
        check("R1 enables in reset", 64'({rd_en, wr_en}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: cyc without stb, stb without cyc
        @(negedge clk);
        cyc = 1'b1; stb = 1'b0; we = 1'b0; #1;
        check("R2 cyc only no enable", 64'({rd_en, wr_en}), 64'd0);
        @(negedge clk); #1;
        check("R2 cyc only no ack", 64'(ack), 64'd0);
        cyc = 1'b0; stb = 1'b1; we = 1'b1; #1;
        check("R2 stb only no enable", 64'({rd_en, wr_en}), 64'd0);
        @(negedge clk); #1;
        check("R2 stb only no ack", 64'(ack), 64'd0);
        stb = 1'b0;

        // Directed lane and offset corners (R3, R4, R7)
        xfer(1'b0, 30'h0000_0010, 4'hF, 32'h0, 1'b0);
        xfer(1'b1, 30'h0000_0011, 4'hF, 32'hDEAD_BEEF, 1'b0);
        xfer(1'b0, 30'h0000_0012, 4'b1000, 32'h0, 1'b1);
        xfer(1'b1, 30'h0000_0013, 4'b0100, 32'h1122_3344, 1'b1);
        xfer(1'b0, 30'h0000_0014, 4'b0000, 32'h0, 1'b0);
        xfer(1'b1, 30'h0000_0015, 4'b1010, 32'hA1B2_C3D4, 1'b0);
        xfer(1'b0, 30'h3FFF_FFFF, 4'b0110, 32'h0, 1'b0);

        // R9: cyc dropped in the response cycle
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 30'h55; sel = 4'hF; #1;
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; #1;
        check("R9 no ack when cyc dropped", 64'(ack), 64'd0);
        check("R9 no data when cyc dropped", 64'(dat_out), 64'd0);
        xfer(1'b1, 30'h56, 4'b0011, 32'hCAFE_F00D, 1'b0);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            xfer(1'($urandom), 30'($urandom), 4'($urandom), $urandom, 1'($urandom));
        end

        @(negedge clk); #1;
        check("R6 ack drops after last transfer", 64'(ack), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule